// File: doc/BRIEF.md
# Direct-Delivery Interrupt Domain

This block is one interrupt domain of a platform interrupt controller that delivers interrupts straight to a single hart, with no message signalling. It watches a vector of raw interrupt lines, one per source. Each source is configured to one of four modes: off, rising edge, level active-high or level active-low. Each source also has its own priority and enable bit. The block continuously selects the best pending, enabled source and drives one interrupt line toward the hart.

Software reaches the block through a simple synchronous register port, with a write strobe and a read strobe that each carry an 8-bit word address. Reads return data one clock after the strobe. Level-sensitive sources hold no latched pending state. Their pending bit is the rectified line itself, recomputed every cycle. Masking, unmasking or claiming a level source can therefore never leave a stale pending bit behind. Edge sources latch a pending bit, and a read of the claim register consumes it.

Address map (word addresses):
- 0x00 is the control register. Bit 0 is the domain enable, and it reads back.
- 0x01 sets an enable bit by source index.
- 0x02 clears an enable bit by source index.
- 0x03 is the top-interrupt register.
- 0x04 is the claim register.
- 0x05 is the pending bitmap.
- 0x06 is the enable bitmap.
- 0x40+i is the mode of source i.
- 0x80+i is the priority of source i.

Top module: `irq_direct_domain`

## Requirements
- R1: For a source in level-high mode (mode code 2), the pending bit read at 0x05 (bit i for source i) always equals the current raw line, whatever happened to it before.
- R2: For a source in level-low mode (mode code 3), the pending bit always equals the inverse of the raw line.
- R3: After an index write to 0x02 masks a level source and its line then drops, the pending bit reads 0 and the top-interrupt register reads 0.
- R4: An index write to 0x01 that unmasks a level source whose rectified line is off raises no interrupt, and a claim read returns 0.
- R5: The top-interrupt (0x03) and claim (0x04) reads return the winning source index in bits 25:16 and its priority in bits 7:0, one cycle after the read strobe.
- R6: When no source is both pending and enabled, the top-interrupt and claim reads return 0.
- R7: The winner has the numerically lowest priority, and ties go to the lowest index. A priority write of 0 is stored as 1, and priorities reset to 1.
- R8: A claim read clears the pending bit of the winning source when it is in edge mode (code 1). The claim read leaves level sources unchanged.
- R9: An edge-mode source becomes pending on a rising edge of its line and holds until claimed or moved out of edge mode. A source in off mode (code 0) is never pending.
- R10: irq_o is high in the cycle after one in which the domain enable is set and the top-interrupt value is nonzero, and low otherwise.
- R11: Synchronous reset clears irq_o, the read data, enables, modes (off) and the domain enable.
- R12: An index write to 0x01 or 0x02 is ignored unless the data is an integer from 1 to 31 with every bit above bit 9 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 31 | Raw source lines; bit i is source i (1..31) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe (a claim read has a side effect) |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 32 | Read data, registered, updated one cycle after rd_en |
| irq_o | output | 1 | Interrupt request to the hart, registered |

## Verification
The bench runs a behavioural model of the domain in parallel with the design and compares irq_o on every clock and rd_data after every read. A wrong pending bit on a level source shows on the very next pending-bitmap, top-interrupt or claim read, and on irq_o one clock later. The masked-then-dropped sequence is replayed explicitly, because a latched level bit would be invisible while masked and would surface only at the unmask. A lost or stuck edge pending bit shows at the next claim read as a wrong index, or as an interrupt that never clears.

// File: rtl/irq_dom_pkg.sv
package irq_dom_pkg;

  typedef enum logic [1:0] {
    SM_OFF  = 2'd0,
    SM_EDGE = 2'd1,
    SM_HIGH = 2'd2,
    SM_LOW  = 2'd3
  } src_mode_e;

  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] A_SETEN = 8'h01;
  localparam logic [ADDR_W-1:0] A_CLREN = 8'h02;
  localparam logic [ADDR_W-1:0] A_TOPI  = 8'h03;
  localparam logic [ADDR_W-1:0] A_CLAIM = 8'h04;
  localparam logic [ADDR_W-1:0] A_PEND  = 8'h05;
  localparam logic [ADDR_W-1:0] A_ENBL  = 8'h06;

  localparam logic [1:0] BANK_MODE = 2'b01;
  localparam logic [1:0] BANK_PRIO = 2'b10;

endpackage

// File: rtl/irq_dom_decode.sv
module irq_dom_decode
  import irq_dom_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int ID_W    = 10
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              ctrl_we,
  output logic [NUM_SRC:1]  mode_we,
  output logic [NUM_SRC:1]  prio_we,
  output logic [NUM_SRC:1]  en_set,
  output logic [NUM_SRC:1]  en_clr
);

  localparam int IDX_W = ADDR_W - 2;

  logic [1:0]       bank;
  logic [IDX_W-1:0] slot;
  logic             idx_clean;
  logic [ID_W-1:0]  widx;

  assign bank      = wr_addr[ADDR_W-1:ADDR_W-2];
  assign slot      = wr_addr[IDX_W-1:0];
  assign widx      = wr_data[ID_W-1:0];
  assign idx_clean = (wr_data[31:ID_W] == '0);
  assign ctrl_we   = wr_en && (wr_addr == A_CTRL);

  always_comb begin
    mode_we = '0;
    prio_we = '0;
    en_set  = '0;
    en_clr  = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (wr_en) begin
        mode_we[i] = (bank == BANK_MODE) && (slot == IDX_W'(i));
        prio_we[i] = (bank == BANK_PRIO) && (slot == IDX_W'(i));
        en_set[i]  = (wr_addr == A_SETEN) && idx_clean && (widx == ID_W'(i));
        en_clr[i]  = (wr_addr == A_CLREN) && idx_clean && (widx == ID_W'(i));
      end
    end
  end

endmodule

// File: rtl/irq_dom_source.sv
module irq_dom_source
  import irq_dom_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw_i,
  input  logic              mode_we,
  input  logic [1:0]        mode_wd,
  input  logic              prio_we,
  input  logic [PRIO_W-1:0] prio_wd,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              claim_i,
  output src_mode_e         mode_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              en_o,
  output logic              pend_o
);

  src_mode_e         mode_q;
  logic [PRIO_W-1:0] prio_q;
  logic              en_q;
  logic              edge_pend_q;
  logic              prev_q;
  logic              rect;
  logic              rise;
  logic              is_level;
  logic              is_edge;

  always_comb begin
    case (mode_q)
      SM_HIGH, SM_EDGE: rect = raw_i;
      SM_LOW:           rect = ~raw_i;
      default:          rect = 1'b0;
    endcase
  end

  assign is_level = (mode_q == SM_HIGH) || (mode_q == SM_LOW);
  assign is_edge  = (mode_q == SM_EDGE);
  assign rise     = rect && !prev_q;

  // Level sources: no storage, the rectified line is the pending bit.
  assign pend_o = is_level ? rect : (is_edge && edge_pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= SM_OFF;
      prio_q      <= PRIO_W'(1);
      en_q        <= 1'b0;
      edge_pend_q <= 1'b0;
      prev_q      <= 1'b0;
    end else begin
      prev_q <= rect;
      if (!is_edge)     edge_pend_q <= 1'b0;
      else if (rise)    edge_pend_q <= 1'b1;
      else if (claim_i) edge_pend_q <= 1'b0;
      if (mode_we) mode_q <= src_mode_e'(mode_wd);
      if (prio_we) prio_q <= (prio_wd == '0) ? PRIO_W'(1) : prio_wd;
      if (en_set)      en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign prio_o = prio_q;
  assign en_o   = en_q;

  assert_level_copy_R1: assert property (@(posedge clk) disable iff (rst)
    is_level |-> (pend_o == (raw_i ^ (mode_q == SM_LOW))));

  assert_edge_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (is_edge && pend_o && !claim_i && !mode_we) |=> pend_o);

  assert_claim_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (is_edge && claim_i && !rise && !mode_we) |=> !pend_o);

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == SM_OFF) |-> !pend_o);

  assert_prio_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    prio_o != '0);

endmodule

// File: rtl/irq_dom_pick.sv
module irq_dom_pick #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 10
) (
  input  logic [NUM_SRC:1]  cand_i,
  input  logic [PRIO_W-1:0] prio_i [1:NUM_SRC],
  output logic [ID_W-1:0]   top_id,
  output logic [PRIO_W-1:0] top_prio
);

  logic hit;

  // Linear scan: strict "less than" keeps the lowest index on ties.
  always_comb begin
    hit      = 1'b0;
    top_id   = '0;
    top_prio = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (cand_i[i] && (!hit || (prio_i[i] < top_prio))) begin
        hit      = 1'b1;
        top_id   = ID_W'(i);
        top_prio = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/irq_direct_domain.sv
module irq_direct_domain
  import irq_dom_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC:1]   src_i,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [31:0]        rd_data,
  output logic               irq_o
);

  localparam int IDX_W   = ADDR_W - 2;
  localparam int ID_LSB  = 16;

  logic              ctrl_we;
  logic [NUM_SRC:1]  mode_we, prio_we, en_set, en_clr;
  logic [NUM_SRC:1]  pend_v, en_v, cand_v, claim_v;
  src_mode_e         mode_arr [1:NUM_SRC];
  logic [PRIO_W-1:0] prio_arr [1:NUM_SRC];
  logic [ID_W-1:0]   top_id;
  logic [PRIO_W-1:0] top_prio;
  logic [31:0]       top_word;
  logic              claim_rd;
  logic              dom_en_q;
  logic [31:0]       rd_next;
  logic [31:0]       rd_q;
  logic              irq_q;

  irq_dom_decode #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_we (ctrl_we),
    .mode_we (mode_we),
    .prio_we (prio_we),
    .en_set  (en_set),
    .en_clr  (en_clr)
  );

  assign claim_rd = rd_en && (rd_addr == A_CLAIM);

  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
    assign claim_v[i] = claim_rd && (top_id == ID_W'(i));
    irq_dom_source #(.PRIO_W(PRIO_W)) u_src (
      .clk     (clk),
      .rst     (rst),
      .raw_i   (src_i[i]),
      .mode_we (mode_we[i]),
      .mode_wd (wr_data[1:0]),
      .prio_we (prio_we[i]),
      .prio_wd (wr_data[PRIO_W-1:0]),
      .en_set  (en_set[i]),
      .en_clr  (en_clr[i]),
      .claim_i (claim_v[i]),
      .mode_o  (mode_arr[i]),
      .prio_o  (prio_arr[i]),
      .en_o    (en_v[i]),
      .pend_o  (pend_v[i])
    );
  end

  assign cand_v = pend_v & en_v;

  irq_dom_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
    .cand_i   (cand_v),
    .prio_i   (prio_arr),
    .top_id   (top_id),
    .top_prio (top_prio)
  );

  assign top_word = (32'(top_id) << ID_LSB) | 32'(top_prio);

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_CTRL:          rd_next = 32'(dom_en_q);
      A_TOPI, A_CLAIM: rd_next = top_word;
      A_PEND:          rd_next = 32'({pend_v, 1'b0});
      A_ENBL:          rd_next = 32'({en_v, 1'b0});
      default: begin
        for (int i = 1; i <= NUM_SRC; i++) begin
          if (rd_addr[IDX_W-1:0] == IDX_W'(i)) begin
            if (rd_addr[ADDR_W-1:IDX_W] == BANK_MODE) rd_next = 32'(mode_arr[i]);
            if (rd_addr[ADDR_W-1:IDX_W] == BANK_PRIO) rd_next = 32'(prio_arr[i]);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_en_q <= 1'b0;
      rd_q     <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (ctrl_we) dom_en_q <= wr_data[0];
      if (rd_en)   rd_q     <= rd_next;
      irq_q <= dom_en_q && (top_id != '0);
    end
  end

  assign rd_data = rd_q;
  assign irq_o   = irq_q;

  assert_top_empty_R6: assert property (@(posedge clk) disable iff (rst)
    ((top_id == '0) == (cand_v == '0)));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(dom_en_q));

  assert_claim_single_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(claim_v));

endmodule

// File: tb/irq_direct_domain_tb.sv
module irq_direct_domain_tb;

  localparam int N = 31;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N:1]   src = '0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         rd_en = 1'b0;
  logic [7:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         irq_o;

  always #10 clk = ~clk;

  irq_direct_domain u_dut (
    .clk(clk), .rst(rst), .src_i(src),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  // Behavioural reference state
  int          m_mode [N+1];
  int          m_prio [N+1];
  bit          m_en   [N+1];
  bit          m_ep   [N+1];
  bit          m_prev [N+1];
  bit          m_dom;
  logic [31:0] m_rd;
  bit          m_irq;

  int    compared   = 0;
  int    mismatched = 0;
  bit    done       = 1'b0;
  string rd_tag     = "R5";

  function automatic bit rect_of(int md, bit raw);
    if (md == 1 || md == 2) return raw;
    if (md == 3) return !raw;
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i <= N; i++) begin
      m_mode[i] = 0; m_prio[i] = 1; m_en[i] = 0; m_ep[i] = 0; m_prev[i] = 0;
    end
    m_dom = 0; m_rd = '0; m_irq = 0;
  endtask

  task automatic tick();
    bit rect [N+1];
    bit pend [N+1];
    int tid, tp, idx, wi;
    bit rd_now, rise, claimed;
    logic [31:0] pmap, emap;
    rd_now = rd_en || rst;
    if (rst) begin
      model_reset();
    end else begin
      tid = 0; tp = 0; pmap = '0; emap = '0;
      for (int i = 1; i <= N; i++) begin
        rect[i] = rect_of(m_mode[i], src[i]);
        pend[i] = (m_mode[i] >= 2) ? rect[i] : (m_mode[i] == 1 && m_ep[i]);
        pmap[i] = pend[i];
        emap[i] = m_en[i];
        if (pend[i] && m_en[i] && (tid == 0 || m_prio[i] < tp)) begin
          tid = i; tp = m_prio[i];
        end
      end
      if (rd_en) begin
        idx = int'(rd_addr[5:0]);
        case (rd_addr)
          8'h00: m_rd = 32'(m_dom);
          8'h03, 8'h04: m_rd = (32'(tid) << 16) | 32'(tp);
          8'h05: m_rd = pmap;
          8'h06: m_rd = emap;
          default: begin
            m_rd = '0;
            if (idx >= 1 && idx <= N && rd_addr[7:6] == 2'b01) m_rd = 32'(m_mode[idx]);
            if (idx >= 1 && idx <= N && rd_addr[7:6] == 2'b10) m_rd = 32'(m_prio[idx]);
          end
        endcase
      end
      m_irq = m_dom && (tid != 0);
      for (int i = 1; i <= N; i++) begin
        rise    = rect[i] && !m_prev[i];
        claimed = rd_en && rd_addr == 8'h04 && tid == i;
        if (m_mode[i] != 1) m_ep[i] = 0;
        else if (rise)      m_ep[i] = 1;
        else if (claimed)   m_ep[i] = 0;
        m_prev[i] = rect[i];
      end
      if (wr_en) begin
        idx = int'(wr_addr[5:0]);
        wi  = int'(wr_data[9:0]);
        if (wr_addr == 8'h00) m_dom = wr_data[0];
        if (wr_addr[7:6] == 2'b01 && idx >= 1 && idx <= N) m_mode[idx] = int'(wr_data[1:0]);
        if (wr_addr[7:6] == 2'b10 && idx >= 1 && idx <= N)
          m_prio[idx] = (wr_data[7:0] == 0) ? 1 : int'(wr_data[7:0]);
        if (wr_data[31:10] == 0 && wi >= 1 && wi <= N) begin
          if (wr_addr == 8'h01) m_en[wi] = 1;
          if (wr_addr == 8'h02) m_en[wi] = 0;
        end
      end
    end
    @(posedge clk);
    #1;
    compared++;
    if (irq_o !== m_irq) begin
      mismatched++;
      $display("FAIL R10 irq_o actual=%0b expected=%0b at %0t", irq_o, m_irq, $time);
    end
    if (rd_now) begin
      compared++;
      if (rd_data !== m_rd) begin
        mismatched++;
        $display("FAIL %s rd_data actual=%h expected=%h at %0t",
                 rst ? "R11" : rd_tag, rd_data, m_rd, $time);
      end
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    rd_tag = tag; rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      mismatched++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    #1;
    idle(3);
    rst = 1'b0;
    // R11: reset state
    rd(8'h00, "R11");   expect32("R11 ctrl", rd_data, 32'h0);
    rd(8'h81, "R11");   expect32("R11 prio reset", rd_data, 32'h1);
    expect32("R11 irq", 32'(irq_o), 32'h0);

    // Level-high source 3, priority 5
    wr(8'h00, 32'h1);
    wr(8'h43, 32'h2);
    wr(8'h83, 32'h5);
    wr(8'h01, 32'd3);
    src[3] = 1'b1;
    rd(8'h03, "R5");    expect32("R5 topi", rd_data, 32'h0003_0005);
    idle(1);            expect32("R10 irq high", 32'(irq_o), 32'h1);
    rd(8'h05, "R1");    expect32("R1 pend copy", rd_data, 32'h8);

    // Mask, drop the line: no stale pending
    wr(8'h02, 32'd3);
    src[3] = 1'b0;
    rd(8'h05, "R3");    expect32("R3 pend after drop", rd_data, 32'h0);
    rd(8'h03, "R3");    expect32("R3 topi after drop", rd_data, 32'h0);
    wr(8'h01, 32'd3);
    idle(2);            expect32("R4 no irq on unmask", 32'(irq_o), 32'h0);
    rd(8'h04, "R4");    expect32("R4 claim empty", rd_data, 32'h0);
    rd(8'h03, "R6");    expect32("R6 topi empty", rd_data, 32'h0);

    // Claim on a level source leaves pending unchanged
    src[3] = 1'b1;
    rd(8'h04, "R5");    expect32("R5 claim id", rd_data, 32'h0003_0005);
    rd(8'h05, "R8");    expect32("R8 level kept", rd_data, 32'h8);
    src[3] = 1'b0;
    rd(8'h05, "R1");    expect32("R1 follows drop", rd_data, 32'h0);

    // Level-low source 7
    wr(8'h47, 32'h3);
    rd(8'h05, "R2");    expect32("R2 low active", rd_data, 32'h80);
    src[7] = 1'b1;
    rd(8'h05, "R2");    expect32("R2 low idle", rd_data, 32'h0);

    // Edge source 10, priority 3
    wr(8'h4A, 32'h1);
    wr(8'h8A, 32'h3);
    wr(8'h01, 32'd10);
    src[10] = 1'b1; idle(1); src[10] = 1'b0;
    idle(2);
    rd(8'h05, "R9");    expect32("R9 edge held", rd_data, 32'h400);
    rd(8'h04, "R8");    expect32("R8 edge claim", rd_data, 32'h000A_0003);
    rd(8'h05, "R8");    expect32("R8 edge cleared", rd_data, 32'h0);

    // Ties and priority 0
    wr(8'h4C, 32'h2); wr(8'h4D, 32'h2);
    wr(8'h8C, 32'h2); wr(8'h8D, 32'h2);
    wr(8'h01, 32'd12); wr(8'h01, 32'd13);
    src[12] = 1'b1; src[13] = 1'b1;
    rd(8'h03, "R7");    expect32("R7 tie low id", rd_data, 32'h000C_0002);
    wr(8'h8D, 32'h0);
    rd(8'h8D, "R7");    expect32("R7 prio zero", rd_data, 32'h1);
    rd(8'h03, "R7");    expect32("R7 lower prio", rd_data, 32'h000D_0001);

    // Off-mode source never pending
    src[20] = 1'b1;
    wr(8'h01, 32'd20);
    rd(8'h05, "R9");    expect32("R9 off quiet", rd_data, 32'h3000);

    // Bad index ignored
    wr(8'h01, 32'h0000_0405);
    wr(8'h02, 32'd0);
    rd(8'h06, "R12");   expect32("R12 enables", rd_data, 32'h0010_3408);

    // Domain disable
    wr(8'h00, 32'h0);
    idle(2);            expect32("R10 irq gated", 32'(irq_o), 32'h0);
    rd(8'h03, "R10");   expect32("R10 topi kept", rd_data, 32'h000D_0001);
    wr(8'h00, 32'h1);

    // Mixed traffic against the model
    wr(8'h45, 32'h1); wr(8'h01, 32'd5);
    wr(8'h46, 32'h3); wr(8'h01, 32'd6);
    wr(8'h86, 32'h4);
    lfsr = 32'hACE1_2345;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      src[3]  = lfsr[3];  src[5]  = lfsr[7];  src[6] = lfsr[11];
      src[10] = lfsr[13]; src[12] = lfsr[17]; src[7] = lfsr[19];
      if (lfsr[24]) begin
        rd_en = 1'b1; rd_addr = lfsr[25] ? 8'h04 : 8'h03; rd_tag = "R8";
      end
      if (lfsr[28] && lfsr[29]) begin
        wr_en = 1'b1; wr_addr = lfsr[30] ? 8'h02 : 8'h01;
        wr_data = {27'd0, lfsr[4:0]};
      end
      tick();
      rd_en = 1'b0; wr_en = 1'b0;
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule